// File: doc/BRIEF.md
# Scatter-Gather Frame-Memory Copy Channel

This block is one DMA channel that copies data out of local frame memory into system memory. Software sets it up through a small register file with a 12-bit address. Every transfer length counts 16-byte units. Every system-memory address is built from a 16-byte-aligned low word and a 12-bit high word, which together form a 44-bit byte address.

In direct mode one launch moves a single block. The block is described by an address pair, a frame offset and a unit count, all held in registers. In chained mode the channel walks a list of eight-word descriptors in system memory. The list starts at the descriptor pointer. Each descriptor gives a destination, a frame offset, a unit count and a link word. The low bits of the link word carry a required marker flag and a last-segment flag.

When the channel stops, it sets a done flag that software clears by writing one to it. The interrupt line follows this flag while the interrupt is enabled. Data leaves the channel as 32-bit words over a request/acknowledge memory port. The frame-memory read port returns data in the same cycle.

Top module: `sgdma_channel`

## Requirements
- R1: Registers are at 0xE00 (mode), 0xE04 (control/status), 0xE20 (address low), 0xE24 (address high), 0xE28 (frame offset), 0xE2C (unit count), 0xE30 (tile), 0xE34 (list pointer low), 0xE38 (list pointer high) and 0xF34 (pitch). Tile, pitch and the direction bit 3 of the pointer-low register are only stored, and every register reads back what was written.
- R2: A launch happens only when one control write sets bit 0 (enable) and bit 1 (start) together. A start written with enable 0 moves nothing and leaves the channel idle.
- R3: In direct mode (mode bit 0 = 0) the channel writes count×4 words. The first byte address is {high[11:0], low[31:4], 4'b0000} and rises by 4 per word. Each word is the frame word read at byte offset (frame offset + 4×i).
- R4: In chained mode (mode bit 0 = 1) the channel reads the eight words of the descriptor at {ptrhigh[11:0], ptrlow[31:4], 4'b0000}. Word 0 is the address low, word 1 the address high, word 2 the frame offset, word 3 the unit count, word 4 the tile, word 5 the link low, word 6 the link high and word 7 the pad. It then copies that segment as in R3.
- R5: After a segment, if bit 1 of the link low is clear, the channel fetches the next descriptor from {linkhigh[11:0], linklow[31:4], 4'b0000}. If bit 1 is set, the chain ends and done is set.
- R6: A descriptor whose link-low bit 0 (marker) is 0 ends the run with done set. Its segment is not copied and no further descriptor is fetched.
- R7: Writing control bit 2 (abort) while the channel is running stops it at once with done set. No memory request follows.
- R8: Done is control/status bit 3. Writing 1 to it clears it, and writing 0 to it leaves it unchanged. The interrupt output equals done AND mode bit 1.
- R9: A launch written while the channel is running is ignored. The active run keeps its original parameters.
- R10: A zero unit count, in direct mode or in a descriptor, completes that segment without any data write.
- R11: A memory request holds its address until it is acknowledged. All request addresses are word aligned.
- R12: After reset the channel is idle, every register reads 0 and the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = data write, 0 = descriptor read |
| mem_addr | output | 44 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 32 | Memory read data |
| fm_addr | output | 32 | Frame-memory byte offset |
| fm_rdata | input | 32 | Frame-memory data for fm_addr, same cycle |
| irq | output | 1 | Transfer-done interrupt |

## Verification
The assertions rely on the memory side acknowledging only a pending request and never in two cycles back to back. The bench's memory model derives each acknowledge from the request seen in the previous cycle and adds a periodic stall. The assertions also rely on frame memory answering combinationally. The bench model computes each frame word from its offset, so the expected write data can be predicted without reading the design. Register writes come one at a time between clock edges, so an abort or a second launch always lands on a defined state of the running transfer.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;
  localparam logic [11:0] OFS_MODE  = 12'hE00;
  localparam logic [11:0] OFS_CTRL  = 12'hE04;
  localparam logic [11:0] OFS_ALO   = 12'hE20;
  localparam logic [11:0] OFS_AHI   = 12'hE24;
  localparam logic [11:0] OFS_FOFS  = 12'hE28;
  localparam logic [11:0] OFS_CNT   = 12'hE2C;
  localparam logic [11:0] OFS_TILE  = 12'hE30;
  localparam logic [11:0] OFS_PLO   = 12'hE34;
  localparam logic [11:0] OFS_PHI   = 12'hE38;
  localparam logic [11:0] OFS_PITCH = 12'hF34;

  localparam int CB_EN    = 0;
  localparam int CB_GO    = 1;
  localparam int CB_ABORT = 2;
  localparam int CB_DONE  = 3;
  localparam int MB_CHAIN = 0;
  localparam int MB_IRQEN = 1;
  localparam int LB_MARK  = 0;
  localparam int LB_LAST  = 1;

  localparam int DESC_WORDS = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_CHECK,
    ST_XFER,
    ST_NEXT
  } eng_state_t;
endpackage

// File: rtl/sgdma_regs.sv
module sgdma_regs
  import sgdma_pkg::*;
#(
  parameter int HI_W  = 12,
  parameter int CNT_W = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [11:0]          reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic                 busy,
  input  logic                 done_set,
  output logic                 chain_mode,
  output logic                 irq_en,
  output logic                 launch,
  output logic                 abort,
  output logic [32+HI_W-1:0]   dir_addr,
  output logic [31:0]          dir_fofs,
  output logic [CNT_W-1:0]     dir_cnt,
  output logic [32+HI_W-1:0]   list_ptr,
  output logic                 done,
  output logic                 irq
);
  localparam int MAW = 32 + HI_W;

  logic [1:0]  mode_q, mode_d;
  logic        en_q, en_d;
  logic        done_q, done_d;
  logic [31:0] alo_q, alo_d, ahi_q, ahi_d, fofs_q, fofs_d, cnt_q, cnt_d;
  logic [31:0] tile_q, tile_d, plo_q, plo_d, phi_q, phi_d, pitch_q, pitch_d;
  logic        wr_ctrl;

  assign wr_ctrl = reg_we && (reg_addr == OFS_CTRL);
  assign launch  = wr_ctrl && reg_wdata[CB_EN] && reg_wdata[CB_GO] && !busy;
  assign abort   = wr_ctrl && reg_wdata[CB_ABORT] && busy;

  always_comb begin
    mode_d  = mode_q;
    en_d    = en_q;
    alo_d   = alo_q;
    ahi_d   = ahi_q;
    fofs_d  = fofs_q;
    cnt_d   = cnt_q;
    tile_d  = tile_q;
    plo_d   = plo_q;
    phi_d   = phi_q;
    pitch_d = pitch_q;
    if (reg_we) begin
      case (reg_addr)
        OFS_MODE:  mode_d  = reg_wdata[1:0];
        OFS_CTRL:  en_d    = reg_wdata[CB_EN];
        OFS_ALO:   alo_d   = reg_wdata;
        OFS_AHI:   ahi_d   = reg_wdata;
        OFS_FOFS:  fofs_d  = reg_wdata;
        OFS_CNT:   cnt_d   = reg_wdata;
        OFS_TILE:  tile_d  = reg_wdata;
        OFS_PLO:   plo_d   = reg_wdata;
        OFS_PHI:   phi_d   = reg_wdata;
        OFS_PITCH: pitch_d = reg_wdata;
        default: ;
      endcase
    end
    // set wins over a same-cycle clear so a finishing run is never lost (R8)
    if (done_set)                        done_d = 1'b1;
    else if (wr_ctrl && reg_wdata[CB_DONE]) done_d = 1'b0;
    else                                 done_d = done_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      en_q    <= 1'b0;
      done_q  <= 1'b0;
      alo_q   <= '0;
      ahi_q   <= '0;
      fofs_q  <= '0;
      cnt_q   <= '0;
      tile_q  <= '0;
      plo_q   <= '0;
      phi_q   <= '0;
      pitch_q <= '0;
    end else begin
      mode_q  <= mode_d;
      en_q    <= en_d;
      done_q  <= done_d;
      alo_q   <= alo_d;
      ahi_q   <= ahi_d;
      fofs_q  <= fofs_d;
      cnt_q   <= cnt_d;
      tile_q  <= tile_d;
      plo_q   <= plo_d;
      phi_q   <= phi_d;
      pitch_q <= pitch_d;
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_MODE:  reg_rdata = {30'd0, mode_q};
      OFS_CTRL:  reg_rdata = {28'd0, done_q, 1'b0, busy, en_q};
      OFS_ALO:   reg_rdata = alo_q;
      OFS_AHI:   reg_rdata = ahi_q;
      OFS_FOFS:  reg_rdata = fofs_q;
      OFS_CNT:   reg_rdata = cnt_q;
      OFS_TILE:  reg_rdata = tile_q;
      OFS_PLO:   reg_rdata = plo_q;
      OFS_PHI:   reg_rdata = phi_q;
      OFS_PITCH: reg_rdata = pitch_q;
      default:   reg_rdata = 32'd0;
    endcase
  end

  assign chain_mode = mode_q[MB_CHAIN];
  assign irq_en     = mode_q[MB_IRQEN];
  assign dir_addr   = {ahi_q[HI_W-1:0], alo_q[31:4], 4'b0000};
  assign dir_fofs   = fofs_q;
  assign dir_cnt    = cnt_q[CNT_W-1:0];
  assign list_ptr   = {phi_q[HI_W-1:0], plo_q[31:4], 4'b0000};
  assign done       = done_q;
  assign irq        = done_q & mode_q[MB_IRQEN];

  logic unused_ok;
  assign unused_ok = ^{alo_q[3:0], ahi_q[31:HI_W], plo_q[3:0], phi_q[31:HI_W],
                       cnt_q[31:CNT_W], tile_q, pitch_q};
endmodule

// File: rtl/sgdma_desc.sv
module sgdma_desc
  import sgdma_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cap_en,
  input  logic [2:0]               cap_idx,
  input  logic [31:0]              cap_data,
  output logic [DESC_WORDS*32-1:0] words
);
  for (genvar g = 0; g < DESC_WORDS; g++) begin : g_word
    logic [31:0] w_q, w_d;
    always_comb begin
      w_d = w_q;
      if (cap_en && (cap_idx == 3'(g))) w_d = cap_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) w_q <= '0;
      else        w_q <= w_d;
    end
    assign words[g*32 +: 32] = w_q;
  end
endmodule

// File: rtl/sgdma_engine.sv
module sgdma_engine
  import sgdma_pkg::*;
#(
  parameter int HI_W  = 12,
  parameter int CNT_W = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 launch,
  input  logic                 abort,
  input  logic                 chain_mode,
  input  logic [32+HI_W-1:0]   dir_addr,
  input  logic [31:0]          dir_fofs,
  input  logic [CNT_W-1:0]     dir_cnt,
  input  logic [32+HI_W-1:0]   list_ptr,
  output logic                 busy,
  output logic                 done_set,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [32+HI_W-1:0]   mem_addr,
  output logic [31:0]          mem_wdata,
  input  logic                 mem_ack,
  input  logic [31:0]          mem_rdata,
  output logic [31:0]          fm_addr,
  input  logic [31:0]          fm_rdata
);
  localparam int MAW = 32 + HI_W;
  localparam int RW  = CNT_W + 2;

  eng_state_t        st_q, st_d;
  logic [2:0]        idx_q, idx_d;
  logic [MAW-1:0]    ptr_q, ptr_d, dst_q, dst_d;
  logic [31:0]       src_q, src_d;
  logic [RW-1:0]     rem_q, rem_d;
  logic              direct_q, direct_d;
  logic              cap_en;
  logic [DESC_WORDS*32-1:0] dw;

  sgdma_desc u_desc (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (cap_en),
    .cap_idx  (idx_q),
    .cap_data (mem_rdata),
    .words    (dw)
  );

  logic [31:0] f_alo, f_ahi, f_ofs, f_size, f_nlo, f_nhi;
  assign f_alo  = dw[0*32 +: 32];
  assign f_ahi  = dw[1*32 +: 32];
  assign f_ofs  = dw[2*32 +: 32];
  assign f_size = dw[3*32 +: 32];
  assign f_nlo  = dw[5*32 +: 32];
  assign f_nhi  = dw[6*32 +: 32];

  always_comb begin
    st_d      = st_q;
    idx_d     = idx_q;
    ptr_d     = ptr_q;
    dst_d     = dst_q;
    src_d     = src_q;
    rem_d     = rem_q;
    direct_d  = direct_q;
    done_set  = 1'b0;
    cap_en    = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = ptr_q + {{(MAW-5){1'b0}}, idx_q, 2'b00};
    mem_wdata = fm_rdata;
    fm_addr   = src_q;
    case (st_q)
      ST_IDLE: begin
        if (launch) begin
          if (chain_mode) begin
            ptr_d    = list_ptr;
            idx_d    = 3'd0;
            direct_d = 1'b0;
            st_d     = ST_FETCH;
          end else if (dir_cnt == '0) begin
            done_set = 1'b1;                    // R10 empty direct run
          end else begin
            dst_d    = dir_addr;
            src_d    = dir_fofs;
            rem_d    = {dir_cnt, 2'b00};
            direct_d = 1'b1;
            st_d     = ST_XFER;
          end
        end
      end
      ST_FETCH: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          cap_en = 1'b1;
          idx_d  = idx_q + 3'd1;
          if (idx_q == 3'(DESC_WORDS - 1)) st_d = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (!f_nlo[LB_MARK]) begin
          done_set = 1'b1;                      // R6 bad link word
          st_d     = ST_IDLE;
        end else if (f_size[CNT_W-1:0] == '0) begin
          st_d = ST_NEXT;
        end else begin
          dst_d = {f_ahi[HI_W-1:0], f_alo[31:4], 4'b0000};
          src_d = f_ofs;
          rem_d = {f_size[CNT_W-1:0], 2'b00};
          st_d  = ST_XFER;
        end
      end
      ST_XFER: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = dst_q;
        if (mem_ack) begin
          dst_d = dst_q + MAW'(4);
          src_d = src_q + 32'd4;
          rem_d = rem_q - RW'(1);
          if (rem_q == RW'(1)) begin
            st_d     = direct_q ? ST_IDLE : ST_NEXT;
            done_set = direct_q;
          end
        end
      end
      ST_NEXT: begin
        if (f_nlo[LB_LAST]) begin
          done_set = 1'b1;
          st_d     = ST_IDLE;
        end else begin
          ptr_d = {f_nhi[HI_W-1:0], f_nlo[31:4], 4'b0000};
          idx_d = 3'd0;
          st_d  = ST_FETCH;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (abort) begin
      st_d     = ST_IDLE;
      done_set = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      idx_q    <= '0;
      ptr_q    <= '0;
      dst_q    <= '0;
      src_q    <= '0;
      rem_q    <= '0;
      direct_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      idx_q    <= idx_d;
      ptr_q    <= ptr_d;
      dst_q    <= dst_d;
      src_q    <= src_d;
      rem_q    <= rem_d;
      direct_q <= direct_d;
    end
  end

  assign busy = (st_q != ST_IDLE);

  logic unused_ok;
  assign unused_ok = ^{f_alo[3:0], f_ahi[31:HI_W], f_size[31:CNT_W], f_nlo[3:2],
                       f_nhi[31:HI_W], dw[4*32 +: 32], dw[7*32 +: 32]};
endmodule

// File: rtl/sgdma_channel.sv
module sgdma_channel #(
  parameter int HI_W  = 12,
  parameter int CNT_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [11:0]         reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  output logic                mem_req,
  output logic                mem_we,
  output logic [32+HI_W-1:0]  mem_addr,
  output logic [31:0]         mem_wdata,
  input  logic                mem_ack,
  input  logic [31:0]         mem_rdata,
  output logic [31:0]         fm_addr,
  input  logic [31:0]         fm_rdata,
  output logic                irq
);
  localparam int MAW = 32 + HI_W;

  logic [1:0] rs_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  logic             busy_w, done_set_w, chain_w, irq_en_w, launch_w, abort_w, done_w;
  logic [MAW-1:0]   dir_addr_w, list_ptr_w;
  logic [31:0]      dir_fofs_w;
  logic [CNT_W-1:0] dir_cnt_w;

  sgdma_regs #(.HI_W(HI_W), .CNT_W(CNT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .busy       (busy_w),
    .done_set   (done_set_w),
    .chain_mode (chain_w),
    .irq_en     (irq_en_w),
    .launch     (launch_w),
    .abort      (abort_w),
    .dir_addr   (dir_addr_w),
    .dir_fofs   (dir_fofs_w),
    .dir_cnt    (dir_cnt_w),
    .list_ptr   (list_ptr_w),
    .done       (done_w),
    .irq        (irq)
  );

  sgdma_engine #(.HI_W(HI_W), .CNT_W(CNT_W)) u_eng (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .launch     (launch_w),
    .abort      (abort_w),
    .chain_mode (chain_w),
    .dir_addr   (dir_addr_w),
    .dir_fofs   (dir_fofs_w),
    .dir_cnt    (dir_cnt_w),
    .list_ptr   (list_ptr_w),
    .busy       (busy_w),
    .done_set   (done_set_w),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .fm_addr    (fm_addr),
    .fm_rdata   (fm_rdata)
  );

  logic unused_ok;
  assign unused_ok = irq_en_w;
endmodule

// File: rtl/sgdma_checker.sv
module sgdma_checker #(
  parameter int MAW = 44
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mem_req,
  input logic           mem_ack,
  input logic [MAW-1:0] mem_addr,
  input logic           irq,
  input logic           busy,
  input logic           done,
  input logic           launch,
  input logic           abort
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !abort) |=> (mem_req && $stable(mem_addr)));   // R11
  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));                                 // R11
  AST_STOP_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);                                                 // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);                                                   // R7
  AST_LAUNCH_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (busy || done));                                            // R2
  AST_IRQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> !irq);                                                 // R8
endmodule

bind sgdma_channel sgdma_checker #(.MAW(32 + HI_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mem_req  (mem_req),
  .mem_ack  (mem_ack),
  .mem_addr (mem_addr),
  .irq      (irq),
  .busy     (busy_w),
  .done     (done_w),
  .launch   (launch_w),
  .abort    (abort_w)
);

// File: tb/sgdma_channel_bench.sv
module sgdma_channel_bench;
  localparam int HI_W = 12;
  localparam int MAW  = 32 + HI_W;

  logic            clk, rst_n;
  logic            reg_we;
  logic [11:0]     reg_addr;
  logic [31:0]     reg_wdata, reg_rdata;
  logic            mem_req, mem_we, mem_ack;
  logic [MAW-1:0]  mem_addr;
  logic [31:0]     mem_wdata, mem_rdata, fm_addr, fm_rdata;
  logic            irq;

  sgdma_channel u_sgdma_channel (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .fm_addr(fm_addr),
    .fm_rdata(fm_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int wr_cnt = 0;
  int rd_cnt = 0;
  logic sb_on = 1'b1;
  string sb_tag = "R3";

  logic [31:0]    dmem [logic [MAW-1:0]];
  logic [MAW-1:0] exp_a [$];
  logic [31:0]    exp_d [$];

  function automatic logic [31:0] fm_fn(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A5A, a[31:16] + 16'h0011};
  endfunction
  function automatic logic [31:0] rd_fn(input logic [MAW-1:0] a);
    if (dmem.exists(a)) return dmem[a];
    return 32'h0;
  endfunction

  assign fm_rdata  = fm_fn(fm_addr);
  assign mem_rdata = rd_fn(mem_addr);

  logic [1:0] stall_q;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      stall_q <= 2'd0;
    end else begin
      stall_q <= stall_q + 2'd1;
      mem_ack <= mem_req && !mem_ack && (stall_q != 2'd3);
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && mem_req && mem_ack) begin
      if (mem_we) begin
        wr_cnt++;
        if (sb_on) begin
          if (exp_a.size() == 0) begin
            chk(1'b0, {sb_tag, " unexpected write"}, {20'd0, mem_addr}, 64'd0);
          end else begin
            logic [MAW-1:0] ea;
            logic [31:0] ed;
            ea = exp_a.pop_front();
            ed = exp_d.pop_front();
            chk(mem_addr == ea, {sb_tag, " write address"}, {20'd0, mem_addr}, {20'd0, ea});
            chk(mem_wdata == ed, {sb_tag, " write data"}, {32'd0, mem_wdata}, {32'd0, ed});
          end
        end
      end else begin
        rd_cnt++;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic push_seg(input logic [MAW-1:0] base, input logic [31:0] ofs, input int units);
    for (int i = 0; i < units * 4; i++) begin
      exp_a.push_back(base + MAW'(i * 4));
      exp_d.push_back(fm_fn(ofs + 32'(i * 4)));
    end
  endtask

  task automatic put_desc(input logic [MAW-1:0] b, input logic [31:0] lo, input logic [31:0] hi,
                          input logic [31:0] ofs, input logic [31:0] sz,
                          input logic [31:0] nlo, input logic [31:0] nhi);
    dmem[b]      = lo;  dmem[b + 4]  = hi;  dmem[b + 8]  = ofs; dmem[b + 12] = sz;
    dmem[b + 16] = 32'h0; dmem[b + 20] = nlo; dmem[b + 24] = nhi; dmem[b + 28] = 32'hFFFF_FFFF;
  endtask

  task automatic wait_done(input string tag);
    logic [31:0] v;
    v = 32'd0;
    for (int i = 0; i < 5000; i++) begin
      reg_read(12'hE04, v);
      if (v[3]) break;
    end
    chk(v[3] == 1'b1 && v[1] == 1'b0, {tag, " run ends with done"}, {32'd0, v}, 64'h8);
  endtask

  task automatic run_start(input string tag);
    sb_tag = tag; wr_cnt = 0; rd_cnt = 0;
    reg_write(12'hE04, 32'h9);   // keep enable, clear done
    reg_write(12'hE04, 32'h3);   // enable + start
  endtask

  initial begin
    logic [31:0] v;
    int snap;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 12'h0; reg_wdata = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R12 reset state
    reg_read(12'hE04, v); chk(v == 32'h0, "R12 control after reset", {32'd0, v}, 64'd0);
    reg_read(12'hE00, v); chk(v == 32'h0, "R12 mode after reset", {32'd0, v}, 64'd0);
    chk(irq == 1'b0, "R12 irq after reset", {63'd0, irq}, 64'd0);

    // R1 stored-only registers
    reg_write(12'hE30, 32'h0000_1234);
    reg_write(12'hF34, 32'hCAFE_0040);
    reg_write(12'hE34, 32'h0000_2009);
    reg_read(12'hE30, v); chk(v == 32'h1234, "R1 tile readback", {32'd0, v}, 64'h1234);
    reg_read(12'hF34, v); chk(v == 32'hCAFE_0040, "R1 pitch readback", {32'd0, v}, 64'hCAFE0040);
    reg_read(12'hE34, v); chk(v == 32'h2009, "R1 pointer-low readback", {32'd0, v}, 64'h2009);

    // R2 start without enable
    reg_write(12'hE00, 32'h2);
    reg_write(12'hE2C, 32'h2);
    wr_cnt = 0;
    reg_write(12'hE04, 32'h2);
    repeat (20) @(negedge clk);
    reg_read(12'hE04, v);
    chk(v[1] == 1'b0 && v[3] == 1'b0, "R2 start without enable ignored", {32'd0, v}, 64'd0);
    chk(wr_cnt == 0, "R2 no writes without enable", 64'(wr_cnt), 64'd0);

    // R3 direct copy, low address bits ignored
    reg_write(12'hE20, 32'h1000_0008);
    reg_write(12'hE24, 32'h0000_0003);
    reg_write(12'hE28, 32'h0000_0040);
    reg_write(12'hE2C, 32'h2);
    push_seg({12'h003, 32'h1000_0000}, 32'h40, 2);
    run_start("R3");
    wait_done("R3");
    chk(exp_a.size() == 0 && wr_cnt == 8, "R3 all direct words written", 64'(wr_cnt), 64'd8);
    chk(irq == 1'b1, "R8 irq with done and enable", {63'd0, irq}, 64'd1);
    reg_write(12'hE04, 32'h1);
    reg_read(12'hE04, v); chk(v[3] == 1'b1, "R8 writing 0 keeps done", {32'd0, v}, 64'h9);
    reg_write(12'hE04, 32'h8);
    reg_read(12'hE04, v); chk(v[3] == 1'b0, "R8 write-one clears done", {32'd0, v}, 64'd0);
    chk(irq == 1'b0, "R8 irq follows done", {63'd0, irq}, 64'd0);

    // R10 zero count direct
    reg_write(12'hE2C, 32'h0);
    run_start("R10");
    wait_done("R10");
    chk(wr_cnt == 0, "R10 zero count writes nothing", 64'(wr_cnt), 64'd0);

    // R4 R5 R10 chained walk
    put_desc(44'h2000, 32'h0000_5000, 32'h0, 32'h100, 32'd1, 32'h0000_2041, 32'h0);
    put_desc(44'h2040, 32'h0000_5555, 32'h0, 32'h000, 32'd0, 32'h0000_2081, 32'h0);
    put_desc(44'h2080, 32'h0000_6004, 32'h1, 32'h200, 32'd2, 32'h0000_0003, 32'h0);
    push_seg(44'h5000, 32'h100, 1);
    push_seg({12'h001, 32'h6000}, 32'h200, 2);
    reg_write(12'hE00, 32'h3);
    reg_write(12'hE34, 32'h0000_2001);
    reg_write(12'hE38, 32'h0);
    run_start("R4");
    wait_done("R4");
    chk(exp_a.size() == 0 && wr_cnt == 12, "R4 chained segments written", 64'(wr_cnt), 64'd12);
    chk(rd_cnt == 24, "R5 three descriptors fetched then stop", 64'(rd_cnt), 64'd24);

    // R6 missing marker
    put_desc(44'h3000, 32'h0000_7000, 32'h0, 32'h300, 32'd1, 32'h0000_3041, 32'h0);
    put_desc(44'h3040, 32'h0000_8000, 32'h0, 32'h400, 32'd1, 32'h0000_3080, 32'h0);
    put_desc(44'h3080, 32'h0000_9000, 32'h0, 32'h500, 32'd1, 32'h0000_0003, 32'h0);
    push_seg(44'h7000, 32'h300, 1);
    reg_write(12'hE34, 32'h0000_3001);
    run_start("R6");
    wait_done("R6");
    chk(wr_cnt == 4 && exp_a.size() == 0, "R6 unmarked segment not copied", 64'(wr_cnt), 64'd4);
    chk(rd_cnt == 16, "R6 no fetch past unmarked descriptor", 64'(rd_cnt), 64'd16);

    // R7 abort
    reg_write(12'hE00, 32'h0);
    reg_write(12'hE2C, 32'd100);
    sb_on = 1'b0;
    run_start("R7");
    repeat (30) @(negedge clk);
    reg_write(12'hE04, 32'h5);
    reg_read(12'hE04, v);
    chk(v[3] == 1'b1 && v[1] == 1'b0, "R7 abort stops with done", {32'd0, v}, 64'h9);
    chk(irq == 1'b0, "R8 irq masked when disabled", {63'd0, irq}, 64'd0);
    snap = wr_cnt;
    repeat (40) @(negedge clk);
    chk(wr_cnt == snap && mem_req == 1'b0, "R7 no traffic after abort", 64'(wr_cnt), 64'(snap));
    chk(snap < 400, "R7 run cut short", 64'(snap), 64'd400);
    sb_on = 1'b1;

    // R9 launch while busy
    reg_write(12'hE2C, 32'd3);
    reg_write(12'hE20, 32'h0000_A000);
    reg_write(12'hE24, 32'h0);
    reg_write(12'hE28, 32'h0000_0800);
    push_seg(44'hA000, 32'h800, 3);
    run_start("R9");
    repeat (6) @(negedge clk);
    reg_write(12'hE2C, 32'd9);
    reg_write(12'hE04, 32'h3);
    wait_done("R9");
    chk(wr_cnt == 12 && exp_a.size() == 0, "R9 second launch ignored", 64'(wr_cnt), 64'd12);

    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule